// File: doc/BRIEF.md
# PCI Configuration Space Responder

This block answers configuration-space reads and writes for one single-function endpoint. It keeps a 16-bit command register and six base address registers. Only the first two base address registers are implemented: an I/O register of size 1 and a 32-bit memory register of size 256 bytes. It returns fixed identity fields. It also serves a linked chain of capability structures: power management, then express, then MSI-X, and optionally an enhanced-allocation structure after them.

A static strap input decides whether the enhanced-allocation structure is in the chain. When the strap is low, the chain ends at MSI-X and the enhanced-allocation offsets read as zero. The identity constants and the capability offsets are parameters.

Requests arrive on a simple port that carries an offset, a byte size, a write enable and write data. A read is answered one cycle after it is accepted, through a registered valid/ready return. A write never produces a response.

Top module: `cfg_space_responder`

## Requirements
- R1: After reset, `rsp_valid` is 0 and the command register reads 0. The I/O base register (offset 0x10) reads 0x00000001, and the memory base register (offset 0x14) reads 0.
- R2: A read at offset 0x000 returns the vendor identity. A read at 0x002 returns the device identity. A read at the header-type offset 0x00E returns 0. The class byte at 0x00B returns the class code. At offset 0x00A, a byte read (`req_size`=0) returns only the subclass, and a word or dword read returns the class code in bits [15:8] and the subclass in bits [7:0].
- R3: A write at offset 0x004 loads `req_wdata[15:0]` into the command register whatever `req_size` is, and a later read at 0x004 returns it.
- R4: A write at offset 0x10 stores the write data with bit 0 forced to 1, because that register is an I/O space register. A write at 0x14 stores the data ORed with the memory type 0. Reads of these offsets return the stored value.
- R5: Writes to any offset other than 0x004, 0x010 and 0x014 change nothing. In particular, base registers 2 to 5 (0x18 to 0x24) always read 0.
- R6: A read at 0x034 returns the power-management offset. Each capability header reads as {next offset, ID} in bits [15:0]. A read at header+1 returns only the next offset. The capability IDs are 0x01 for power management, 0x10 for express and 0x11 for MSI-X. The power-management header points to express, and the express header points to MSI-X.
- R7: When `ea_strap` is 1, the MSI-X next pointer (in its header and at header+1) is the enhanced-allocation offset. When `ea_strap` is 0, that next pointer is 0.
- R8: With the strap set, the enhanced-allocation header reads as entry count 4 in bits [21:16] with ID 0x14 in bits [7:0], and header+1 reads 0. With the strap clear, every enhanced-allocation offset reads 0.
- R9: With the strap set, a read at an offset from header+4 to header+63 returns table dword (offset − header − 4)/4, shifted right by 8 × (offset mod 4). The table holds 15 stored dwords.
- R10: A read at express header+4 (the device capabilities register) returns 0x00000001, which reports a 256-byte maximum payload.
- R11: A read at any offset not listed above, and any read of a base-register offset that is not dword aligned, returns 0.
- R12: An accepted read raises `rsp_valid` on the next cycle. `rsp_valid` and `rsp_rdata` hold while `rsp_ready` is low. `req_ready` is low exactly while a response is waiting with `rsp_ready` low.
- R13: An accepted write produces no response: `rsp_valid` is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ea_strap | input | 1 | Enables the enhanced-allocation capability in the chain |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with `req_valid` |
| req_addr | input | 12 | Configuration byte offset |
| req_size | input | 2 | Access size: 0 byte, 1 word, 2 or 3 dword |
| req_we | input | 1 | 1 for write, 0 for read |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Consumer takes the read data |
| rsp_rdata | output | 32 | Read data |

## Verification
The properties assume that `ea_strap` is steady enough to be sampled with each request. They also assume that `req_valid` is only read together with `req_ready` to mark acceptance, so that a request refused under back-pressure has no effect. The bench changes the strap only between transactions. It waits for each response to drain before it presents the next request, and it holds `rsp_ready` low for random stretches to exercise the hold behaviour. Offsets are drawn from a list of meaningful locations mixed with random 12-bit values, and a model in the bench follows every write.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_WIDE  = 2'd3
    } cfg_size_e;

    // Fixed header offsets; the positions are the standard layout.
    localparam logic [11:0] OFS_VENDOR    = 12'h000;
    localparam logic [11:0] OFS_DEVICE    = 12'h002;
    localparam logic [11:0] OFS_CMD       = 12'h004;
    localparam logic [11:0] OFS_SUBCLASS  = 12'h00A;
    localparam logic [11:0] OFS_CLASS     = 12'h00B;
    localparam logic [11:0] OFS_HDR_TYPE  = 12'h00E;
    localparam logic [11:0] OFS_BAR_FIRST = 12'h010;
    localparam logic [11:0] OFS_CAP_PTR   = 12'h034;

    localparam int NUM_BAR = 6;
    localparam int NUM_WRITABLE_BAR = 2;

    // Capability identifiers
    localparam logic [7:0] CAPID_PM   = 8'h01;
    localparam logic [7:0] CAPID_EXP  = 8'h10;
    localparam logic [7:0] CAPID_MSIX = 8'h11;
    localparam logic [7:0] CAPID_EA   = 8'h14;

    localparam logic [5:0]  EA_ENTRY_COUNT = 6'd4;
    localparam int          EA_DWORDS      = 15;
    localparam logic [11:0] EA_BYTES       = 12'(EA_DWORDS * 4 + 4);
    localparam logic [31:0] DEVCAP_MPS_256 = 32'h0000_0001;

    localparam logic [31:0] MEM_BAR_SIZE = 32'd256;

    // Enhanced-allocation base and size words
    localparam logic [31:0] EA_IS64     = 32'h0000_0002;
    localparam logic [31:0] EA_BASE_LO0 = 32'h0000_1000;
    localparam logic [31:0] EA_BASE_LO1 = 32'h0002_0000;
    localparam logic [31:0] EA_BASE_LO2 = 32'h0004_0000;
    localparam logic [31:0] EA_BASE_HI2 = 32'h0000_0001;
    localparam logic [31:0] EA_BASE_LO4 = 32'h0008_0000;
    localparam logic [31:0] EA_BASE_HI4 = 32'h0000_0002;
    localparam logic [31:0] EA_SIZE_LO  = 32'h0000_fffc;
    localparam logic [31:0] EA_SIZE_HI  = 32'h0000_0001;

    // Space-type bit ORed into a written base register.
    function automatic logic [31:0] bar_type(int n);
        return (n == 0) ? 32'h1 : 32'h0;
    endfunction

    // Stored body of the enhanced-allocation structure (header excluded).
    function automatic logic [31:0] ea_word(logic [3:0] idx);
        case (idx)
            4'd0:    return (32'd2 << 8) | 32'd2;
            4'd1:    return EA_BASE_LO0;
            4'd2:    return 32'd0;
            4'd3:    return (32'd1 << 4) | 32'd2;
            4'd4:    return EA_BASE_LO1;
            4'd5:    return MEM_BAR_SIZE - 32'd1;
            4'd6:    return (32'd2 << 4) | 32'd3;
            4'd7:    return EA_BASE_LO2 | EA_IS64;
            4'd8:    return EA_SIZE_LO;
            4'd9:    return EA_BASE_HI2;
            4'd10:   return (32'd4 << 4) | 32'd4;
            4'd11:   return EA_BASE_LO4 | EA_IS64;
            4'd12:   return EA_SIZE_LO | EA_IS64;
            4'd13:   return EA_BASE_HI4;
            4'd14:   return EA_SIZE_HI;
            default: return 32'd0;
        endcase
    endfunction

endpackage

// File: rtl/cfg_regs.sv
module cfg_regs
    import cfg_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [11:0]                addr,
    input  logic [31:0]                wdata,
    output logic [15:0]                cmd,
    output logic [NUM_BAR-1:0][31:0]   bars
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd <= 16'h0000;
        end else if (wr_en && addr == OFS_CMD) begin
            cmd <= wdata[15:0];
        end
    end

    for (genvar n = 0; n < NUM_BAR; n++) begin : g_bar
        if (n < NUM_WRITABLE_BAR) begin : g_impl
            localparam logic [11:0] MY_OFS = OFS_BAR_FIRST + 12'(4 * n);
            logic [31:0] bar_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    bar_q <= bar_type(n);
                end else if (wr_en && addr == MY_OFS) begin
                    bar_q <= wdata | bar_type(n);
                end
            end
            assign bars[n] = bar_q;
        end else begin : g_absent
            assign bars[n] = 32'd0;
        end
    end

endmodule

// File: rtl/cfg_cap_rom.sv
module cfg_cap_rom
    import cfg_pkg::*;
#(
    parameter logic [11:0] PM_OFS   = 12'h040,
    parameter logic [11:0] EXP_OFS  = 12'h048,
    parameter logic [11:0] MSIX_OFS = 12'h084,
    parameter logic [11:0] EA_OFS   = 12'h090
) (
    input  logic [11:0] addr,
    input  logic        ea_en,
    output logic        hit,
    output logic [31:0] data
);

    localparam logic [11:0] EA_BODY_LO = EA_OFS + 12'd4;
    localparam logic [11:0] EA_BODY_HI = EA_OFS + EA_BYTES;

    logic        in_body;
    logic [11:0] rel;
    logic [3:0]  idx;
    logic [4:0]  shamt;
    logic [7:0]  msix_next;

    assign in_body   = ea_en && (addr >= EA_BODY_LO) && (addr < EA_BODY_HI);
    assign rel       = addr - EA_BODY_LO;
    assign idx       = 4'(rel >> 2);
    assign shamt     = {addr[1:0], 3'b000};
    assign msix_next = ea_en ? EA_OFS[7:0] : 8'h00;

    always_comb begin
        hit  = 1'b1;
        data = 32'd0;
        if (in_body) begin
            data = ea_word(idx) >> shamt;
        end else begin
            case (addr)
                OFS_CAP_PTR:          data = {24'd0, PM_OFS[7:0]};
                PM_OFS:               data = {16'd0, EXP_OFS[7:0], CAPID_PM};
                PM_OFS + 12'd1:       data = {24'd0, EXP_OFS[7:0]};
                EXP_OFS:              data = {16'd0, MSIX_OFS[7:0], CAPID_EXP};
                EXP_OFS + 12'd1:      data = {24'd0, MSIX_OFS[7:0]};
                EXP_OFS + 12'd4:      data = DEVCAP_MPS_256;
                MSIX_OFS:             data = {16'd0, msix_next, CAPID_MSIX};
                MSIX_OFS + 12'd1:     data = {24'd0, msix_next};
                EA_OFS:               data = ea_en ? {10'd0, EA_ENTRY_COUNT, 8'd0, CAPID_EA}
                                                   : 32'd0;
                EA_OFS + 12'd1:       data = 32'd0;
                default:              hit  = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/cfg_rsp_stage.sv
module cfg_rsp_stage (
    input  logic        clk,
    input  logic        rst,
    input  logic        load,
    input  logic [31:0] load_data,
    input  logic        rsp_ready,
    output logic        rsp_valid,
    output logic [31:0] rsp_rdata,
    output logic        can_accept
);

    assign can_accept = !rsp_valid || rsp_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= 32'd0;
        end else if (can_accept) begin
            rsp_valid <= load;
            if (load) begin
                rsp_rdata <= load_data;
            end
        end
    end

endmodule

// File: rtl/cfg_space_responder.sv
module cfg_space_responder
    import cfg_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID = 16'h1ab8,
    parameter logic [15:0] DEVICE_ID = 16'h5432,
    parameter logic [7:0]  CLASS_ID  = 8'h07,
    parameter logic [7:0]  SUBCL_ID  = 8'h80,
    parameter logic [11:0] PM_OFS    = 12'h040,
    parameter logic [11:0] EXP_OFS   = 12'h048,
    parameter logic [11:0] MSIX_OFS  = 12'h084,
    parameter logic [11:0] EA_OFS    = 12'h090
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ea_strap,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [11:0] req_addr,
    input  logic [1:0]  req_size,
    input  logic        req_we,
    input  logic [31:0] req_wdata,
    output logic        rsp_valid,
    input  logic        rsp_ready,
    output logic [31:0] rsp_rdata
);

    localparam logic [11:0] BAR_END = OFS_BAR_FIRST + 12'(4 * NUM_BAR);

    logic                     fire;
    logic                     wr_fire;
    logic                     rd_fire;
    logic [15:0]              cmd;
    logic [NUM_BAR-1:0][31:0] bars;
    logic                     cap_hit;
    logic [31:0]              cap_data;
    logic [31:0]              hdr_data;
    logic [31:0]              rd_data;
    logic [11:0]              bar_rel;
    logic [2:0]               bar_idx;
    cfg_size_e                size_e;

    assign fire    = req_valid && req_ready;
    assign wr_fire = fire && req_we;
    assign rd_fire = fire && !req_we;
    assign size_e  = cfg_size_e'(req_size);

    cfg_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_fire),
        .addr  (req_addr),
        .wdata (req_wdata),
        .cmd   (cmd),
        .bars  (bars)
    );

    cfg_cap_rom #(
        .PM_OFS   (PM_OFS),
        .EXP_OFS  (EXP_OFS),
        .MSIX_OFS (MSIX_OFS),
        .EA_OFS   (EA_OFS)
    ) u_caps (
        .addr  (req_addr),
        .ea_en (ea_strap),
        .hit   (cap_hit),
        .data  (cap_data)
    );

    assign bar_rel = req_addr - OFS_BAR_FIRST;
    assign bar_idx = 3'(bar_rel >> 2);

    always_comb begin
        hdr_data = 32'd0;
        case (req_addr)
            OFS_VENDOR:   hdr_data = {16'd0, VENDOR_ID};
            OFS_DEVICE:   hdr_data = {16'd0, DEVICE_ID};
            OFS_CMD:      hdr_data = {16'd0, cmd};
            OFS_SUBCLASS: hdr_data = (size_e == SZ_BYTE) ? {24'd0, SUBCL_ID}
                                                         : {16'd0, CLASS_ID, SUBCL_ID};
            OFS_CLASS:    hdr_data = {24'd0, CLASS_ID};
            OFS_HDR_TYPE: hdr_data = 32'd0;
            default: begin
                if (req_addr >= OFS_BAR_FIRST && req_addr < BAR_END
                    && req_addr[1:0] == 2'b00) begin
                    hdr_data = bars[bar_idx];
                end
            end
        endcase
    end

    assign rd_data = cap_hit ? cap_data : hdr_data;

    cfg_rsp_stage u_rsp (
        .clk        (clk),
        .rst        (rst),
        .load       (rd_fire),
        .load_data  (rd_data),
        .rsp_ready  (rsp_ready),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata),
        .can_accept (req_ready)
    );

endmodule

// File: rtl/cfg_space_responder_chk.sv
module cfg_space_responder_chk #(
    parameter logic [11:0] MSIX_OFS = 12'h084
) (
    input logic        clk,
    input logic        rst,
    input logic        ea_strap,
    input logic        req_valid,
    input logic        req_ready,
    input logic [11:0] req_addr,
    input logic        req_we,
    input logic        rsp_valid,
    input logic        rsp_ready,
    input logic [31:0] rsp_rdata
);

    logic acc_rd;
    logic acc_wr;
    assign acc_rd = req_valid && req_ready && !req_we;
    assign acc_wr = req_valid && req_ready && req_we;

    p_reset_idle_r1: assert property (@(posedge clk) rst |=> !rsp_valid)
        else $error("R1: response valid after reset");

    p_read_answers_r12: assert property (@(posedge clk) disable iff (rst)
        acc_rd |=> rsp_valid)
        else $error("R12: read not answered");

    p_hold_r12: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata))
        else $error("R12: response not held");

    p_backpressure_r12: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_ready |-> !req_ready)
        else $error("R12: request accepted while stalled");

    p_write_silent_r13: assert property (@(posedge clk) disable iff (rst)
        acc_wr |=> !rsp_valid)
        else $error("R13: write produced a response");

    p_io_space_bit_r4: assert property (@(posedge clk) disable iff (rst)
        acc_rd && req_addr == 12'h010 |=> rsp_rdata[0])
        else $error("R4: I/O space bit clear");

    p_chain_end_r7: assert property (@(posedge clk) disable iff (rst)
        acc_rd && !ea_strap && req_addr == MSIX_OFS + 12'd1 |=> rsp_rdata == 32'd0)
        else $error("R7: chain not terminated");

endmodule

bind cfg_space_responder cfg_space_responder_chk #(.MSIX_OFS(MSIX_OFS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ea_strap  (ea_strap),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_we    (req_we),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_rdata (rsp_rdata)
);

// File: tb/cfg_space_responder_tb.sv
module cfg_space_responder_tb;
    import cfg_pkg::*;

    localparam logic [15:0] VID  = 16'h1ab8;
    localparam logic [15:0] DID  = 16'h5432;
    localparam logic [7:0]  CLS  = 8'h07;
    localparam logic [7:0]  SUB  = 8'h80;
    localparam logic [11:0] PM   = 12'h040;
    localparam logic [11:0] EXP  = 12'h048;
    localparam logic [11:0] MSIX = 12'h084;
    localparam logic [11:0] EA   = 12'h090;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ea_strap = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [11:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_we = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [31:0] rsp_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Bench model of writable state
    logic [15:0] m_cmd;
    logic [31:0] m_bar0;
    logic [31:0] m_bar1;

    always #2.5 clk = ~clk;

    cfg_space_responder u_dut (
        .clk(clk), .rst(rst), .ea_strap(ea_strap),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_size(req_size), .req_we(req_we),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata)
    );

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] tb_ea(int i);
        logic [31:0] t [EA_DWORDS];
        t = '{32'h0000_0202, EA_BASE_LO0, 32'h0, 32'h0000_0012, EA_BASE_LO1,
              32'h0000_00ff, 32'h0000_0023, EA_BASE_LO2 | 32'h2, EA_SIZE_LO,
              EA_BASE_HI2, 32'h0000_0044, EA_BASE_LO4 | 32'h2,
              EA_SIZE_LO | 32'h2, EA_BASE_HI4, EA_SIZE_HI};
        return t[i];
    endfunction

    function automatic logic [31:0] exp_read(logic [11:0] a, logic [1:0] sz, bit s);
        logic [7:0] mn;
        mn = s ? EA[7:0] : 8'h00;
        if (s && a >= EA + 12'd4 && a < EA + 12'd64)
            return tb_ea(int'((a - EA - 12'd4) >> 2)) >> (8 * int'(a[1:0]));
        case (a)
            12'h000: return {16'd0, VID};
            12'h002: return {16'd0, DID};
            12'h004: return {16'd0, m_cmd};
            12'h00A: return (sz == 2'd0) ? {24'd0, SUB} : {16'd0, CLS, SUB};
            12'h00B: return {24'd0, CLS};
            12'h010: return m_bar0;
            12'h014: return m_bar1;
            12'h034: return {24'd0, PM[7:0]};
            PM:        return {16'd0, EXP[7:0], 8'h01};
            PM + 1:    return {24'd0, EXP[7:0]};
            EXP:       return {16'd0, MSIX[7:0], 8'h10};
            EXP + 1:   return {24'd0, MSIX[7:0]};
            EXP + 4:   return 32'h1;
            MSIX:      return {16'd0, mn, 8'h11};
            MSIX + 1:  return {24'd0, mn};
            EA:        return s ? 32'h0004_0014 : 32'h0;
            default:   return 32'h0;
        endcase
    endfunction

    function automatic string tag_for(logic [11:0] a, bit s);
        if (a >= EA + 12'd4 && a < EA + 12'd64) return s ? "R9" : "R8";
        if (a == EA || a == EA + 1) return "R8";
        if (a == MSIX || a == MSIX + 1) return "R7";
        if (a == EXP + 4) return "R10";
        if (a == 12'h034 || a == PM || a == PM + 1 || a == EXP || a == EXP + 1) return "R6";
        if (a == 12'h004) return "R3";
        if (a == 12'h010 || a == 12'h014) return "R4";
        if (a >= 12'h018 && a < 12'h028) return "R5";
        if (a <= 12'h00E) return "R2";
        return "R11";
    endfunction

    task automatic do_read(logic [11:0] a, logic [1:0] sz, string tag);
        logic [31:0] exp;
        logic [31:0] first;
        int stall;
        exp = exp_read(a, sz, ea_strap);
        @(negedge clk);
        req_valid = 1'b1; req_we = 1'b0; req_addr = a; req_size = sz;
        @(negedge clk);
        req_valid = 1'b0;
        check(rsp_valid == 1'b1, "R12 valid after accepted read", 32'(rsp_valid), 32'd1);
        check(rsp_rdata == exp, tag, rsp_rdata, exp);
        first = rsp_rdata;
        stall = int'($urandom_range(0, 3));
        for (int k = 0; k < stall; k++) begin
            @(negedge clk);
            check(rsp_valid && rsp_rdata == first && !req_ready,
                  "R12 hold under back-pressure", rsp_rdata, first);
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        check(rsp_valid == 1'b0, "R12 drained", 32'(rsp_valid), 32'd0);
    endtask

    task automatic do_write(logic [11:0] a, logic [1:0] sz, logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_we = 1'b1; req_addr = a; req_size = sz; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_we = 1'b0;
        check(rsp_valid == 1'b0, "R13 write silent", 32'(rsp_valid), 32'd0);
        if (a == 12'h004) m_cmd = d[15:0];
        if (a == 12'h010) m_bar0 = d | 32'h1;
        if (a == 12'h014) m_bar1 = d;
    endtask

    initial begin
        logic [11:0] picks [20];
        void'($urandom(32'd1234));
        picks = '{12'h000, 12'h002, 12'h004, 12'h00A, 12'h00B, 12'h00E, 12'h010,
                  12'h014, 12'h018, 12'h024, 12'h034, PM, PM + 1, EXP, EXP + 1,
                  EXP + 4, MSIX, MSIX + 1, EA, EA + 1};
        m_cmd = 16'h0; m_bar0 = 32'h1; m_bar1 = 32'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(rsp_valid == 1'b0, "R1 idle after reset", 32'(rsp_valid), 32'd0);
        do_read(12'h004, 2'd1, "R1 command reset");
        do_read(12'h010, 2'd2, "R1 BAR0 reset");
        do_read(12'h014, 2'd2, "R1 BAR1 reset");

        // Directed corners
        do_read(12'h00A, 2'd0, "R2 subclass byte");
        do_read(12'h00A, 2'd1, "R2 class word");
        do_read(12'h00E, 2'd0, "R2 header type");
        do_write(12'h004, 2'd0, 32'hdead_0147);
        do_read(12'h004, 2'd1, "R3 command");
        do_write(12'h010, 2'd2, 32'h0000_c000);
        do_read(12'h010, 2'd2, "R4 BAR0 space bit forced");
        do_write(12'h014, 2'd2, 32'hfeed_0001);
        do_read(12'h014, 2'd2, "R4 BAR1 stored");
        do_write(12'h018, 2'd2, 32'hffff_ffff);
        do_read(12'h018, 2'd2, "R5 BAR2 ignores write");
        do_write(12'h000, 2'd2, 32'h1234_5678);
        do_read(12'h000, 2'd1, "R5 vendor ignores write");
        do_read(12'h012, 2'd2, "R11 unaligned BAR");
        do_read(12'h300, 2'd2, "R11 unimplemented");
        do_read(12'h034, 2'd0, "R6 cap pointer");
        do_read(EXP + 4, 2'd2, "R10 payload");
        ea_strap = 1'b0;
        do_read(MSIX + 1, 2'd0, "R7 chain ends");
        do_read(EA, 2'd2, "R8 header hidden");
        do_read(EA + 12'd8, 2'd2, "R8 body hidden");
        ea_strap = 1'b1;
        do_read(MSIX, 2'd1, "R7 points to EA");
        do_read(EA, 2'd2, "R8 entry count");
        do_read(EA + 12'd4, 2'd2, "R9 first dword");
        do_read(EA + 12'd3 + 12'd4, 2'd0, "R9 byte shift");
        do_read(EA + 12'd63, 2'd0, "R9 last byte");
        do_read(EA + 12'd64, 2'd2, "R11 past EA body");

        // Random mix
        for (int i = 0; i < 400; i++) begin
            logic [11:0] a;
            logic [1:0]  sz;
            if ($urandom_range(0, 9) == 0) ea_strap = $urandom_range(0, 1) == 1;
            case ($urandom_range(0, 2))
                0:       a = picks[$urandom_range(0, 19)];
                1:       a = EA + 12'($urandom_range(0, 70));
                default: a = 12'($urandom);
            endcase
            sz = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 3) == 0)
                do_write(a, sz, $urandom);
            else
                do_read(a, sz, tag_for(a, ea_strap));
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%08h expected=%08h", 32'd0, 32'd1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule